// File: doc/BRIEF.md
# Memory Area Controller with Boot-Area Swap

This block turns single word, halfword or byte requests from a bus master into strobe sequences on a shared memory interface. The upper two bits of the request address pick one of four logical areas, each spanning 1 MByte, and the remaining bits become the address within that area. Every physical area has its own active-low chip select. Every physical area also has three configuration settings: a data width of 8, 16 or 32 bits, a number of wait states and a number of stop states. When a request is wider than the device behind the selected area, the block splits it into consecutive narrow sub-cycles and assembles the read data into the lanes of one 32-bit word.

A swap bit exchanges logical area 0 with logical area 3. Area 0 is the one fetched from after reset. Setting the bit lets the fast on-chip memory that normally sits in area 3 answer at area 0 while the boot device moves to area 3. A wait input from the device can stretch any sub-cycle beyond its programmed wait count. The requester sees `busy` while a transfer runs and a one-cycle `done` when its last sub-cycle has ended.

Top module: `mem_area_ctrl`

## Requirements
- R1: Logical area = req_addr[AREA_W+1:AREA_W]. During a sub-cycle exactly one bit of mem_cs_n (the physical area's bit) is low. Outside sub-cycles, and while in reset, all of mem_cs_n is high.
- R2: The swap bit is clear after reset and loads swap_in on a clock edge where swap_we is high. A request accepted on a later edge with the bit set drives physical area 3 for logical area 0 and physical area 0 for logical area 3. Areas 1 and 2 are unaffected. Changing the bit during a transfer does not change the chip select of that transfer.
- R3: A sub-cycle of a physical area with wait setting W (cfg_wait[a*WAIT_W +: WAIT_W]) keeps its strobes asserted for W+1 cycles when mem_wait is low.
- R4: A sub-cycle ends only on a cycle edge where its wait count is used up and mem_wait is low. While mem_wait holds it open, address and chip select stay unchanged.
- R5: After every sub-cycle of a physical area with stop setting S (cfg_stop[a*WAIT_W +: WAIT_W]), S cycles follow in which every chip select and every strobe is high, before the next chip select or a new request.
- R6: cfg_width[2a+1:2a] gives the device width of physical area a: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. req_size: 0 = byte, 1 = halfword, 2 or 3 = word. Requests are naturally aligned. An access of B bytes to a device of D bytes takes max(1, B/D) sub-cycles. Their addresses ascend in steps of D starting at the request address, so the lower part comes first. mem_addr = {req_addr[AREA_W-1:2], low bits}.
- R7: Data sits in little-endian 32-bit lanes, with byte lane = address bits [1:0]. In a sub-cycle at offset o, the device port mem_wdata[8D-1:0] carries the lanes starting at o with its lowest log2(D) bits cleared. Read data returned on mem_rdata[8D-1:0] fills the same lanes of rdata. Lanes that no sub-cycle covers read as zero.
- R8: mem_oe_n is low during read sub-cycles and mem_we_n is low during write sub-cycles. They are never low together.
- R9: mem_ub_n is low only during a sub-cycle to a 16-bit area whose access touches the upper byte: a halfword or word access, or a byte access with address bit 0 set. mem_addr[0] acts as the active-low lower-byte select.
- R10: done is high for exactly one cycle, the cycle after the final sub-cycle ends. rdata holds the read result in that cycle.
- R11: A req pulse is accepted only while busy is low, and busy is high from the next cycle until the last stop state has passed. A req that arrives while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a transfer (accepted when idle) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | AREA_W+2 | Area select and byte address within the area |
| req_wdata | input | 32 | Write data in byte lanes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read data |
| swap_we | input | 1 | Load the swap bit |
| swap_in | input | 1 | New swap bit value |
| cfg_width | input | 8 | Device width code per physical area |
| cfg_wait | input | 4*WAIT_W | Wait state count per physical area |
| cfg_stop | input | 4*WAIT_W | Stop state count per physical area |
| mem_wait | input | 1 | Device request to extend the current sub-cycle |
| mem_rdata | input | 32 | Device read data |
| mem_cs_n | output | 4 | Active-low chip selects, one per physical area |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_ub_n | output | 1 | Active-low upper-byte strobe |
| mem_addr | output | AREA_W | Address within the area |
| mem_wdata | output | 32 | Device write data |

## Verification
The assertions watch the properties that hold every cycle: at most one chip select low, output and write enables never low together, all strobes high whenever no chip select is active, address and select frozen while the device wait input holds a finished count, single-cycle done, and busy following an accepted request. The exact sub-cycle count, the address and lane of each sub-cycle, the lengths of the wait and stop phases, the upper-byte strobe, the read-data assembly and the area remapping under swap depend on configuration. The bench shows these by sweeping every width rotation, swap setting, area, size, aligned offset, direction and two device-wait patterns against a cycle schedule it computes itself.

// File: rtl/mem_area_ctrl.sv
module mem_area_ctrl #(
  parameter int AREA_W = 20,
  parameter int WAIT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  req_we,
  input  logic [1:0]            req_size,
  input  logic [AREA_W+1:0]     req_addr,
  input  logic [31:0]           req_wdata,
  output logic                  busy,
  output logic                  done,
  output logic [31:0]           rdata,
  input  logic                  swap_we,
  input  logic                  swap_in,
  input  logic [7:0]            cfg_width,
  input  logic [4*WAIT_W-1:0]   cfg_wait,
  input  logic [4*WAIT_W-1:0]   cfg_stop,
  input  logic                  mem_wait,
  input  logic [31:0]           mem_rdata,
  output logic [3:0]            mem_cs_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic                  mem_ub_n,
  output logic [AREA_W-1:0]     mem_addr,
  output logic [31:0]           mem_wdata
);
  typedef enum logic [1:0] {S_IDLE, S_ACC, S_STOP} state_t;

  state_t              st;
  logic                swap_q, we_q, fin_q, done_q;
  logic [1:0]          area_q, size_q, beat, last_q;
  logic [AREA_W-1:0]   addr_q;
  logic [31:0]         wdata_q, rdata_q;
  logic [WAIT_W-1:0]   cnt;

  wire [1:0] req_area = req_addr[AREA_W+1:AREA_W];
  wire [1:0] req_phys = (swap_q && (req_area == 2'd0 || req_area == 2'd3)) ? ~req_area : req_area;
  wire [1:0] a_sel    = (st == S_IDLE) ? req_phys : area_q;
  wire [1:0] w_raw    = cfg_width[{a_sel, 1'b0} +: 2];
  wire [1:0] dl       = (w_raw == 2'd3) ? 2'd2 : w_raw;
  wire [WAIT_W-1:0] wait_n = cfg_wait[a_sel*WAIT_W +: WAIT_W];
  wire [WAIT_W-1:0] stop_n = cfg_stop[a_sel*WAIT_W +: WAIT_W];
  wire [1:0] req_sz   = (req_size == 2'd3) ? 2'd2 : req_size;
  wire [1:0] nlog     = (req_sz > dl) ? req_sz - dl : 2'd0;
  wire [1:0] req_last = (nlog == 2'd0) ? 2'd0 : (nlog == 2'd1) ? 2'd1 : 2'd3;
  wire [1:0] step     = (dl == 2'd0) ? beat : (dl == 2'd1) ? {beat[0], 1'b0} : 2'd0;
  wire [1:0] off      = addr_q[1:0] + step;
  wire [1:0] lane     = (dl == 2'd0) ? off : (dl == 2'd1) ? {off[1], 1'b0} : 2'd0;
  wire [3:0] dmask    = (dl == 2'd0) ? 4'b0001 : (dl == 2'd1) ? 4'b0011 : 4'b1111;
  wire [3:0] bmask    = dmask << lane;
  wire [31:0] rd_sh   = mem_rdata << {lane, 3'b000};
  wire in_acc         = (st == S_ACC);
  wire acc_end        = in_acc && (cnt == '0) && !mem_wait;
  wire is_last        = (beat == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; swap_q <= 1'b0; we_q <= 1'b0; fin_q <= 1'b0; done_q <= 1'b0;
      area_q <= '0; size_q <= '0; beat <= '0; last_q <= '0;
      addr_q <= '0; wdata_q <= '0; rdata_q <= '0; cnt <= '0;
    end else begin
      done_q <= acc_end && is_last;
      if (swap_we) swap_q <= swap_in;
      case (st)
        S_IDLE: if (req) begin
          area_q  <= req_phys;
          addr_q  <= req_addr[AREA_W-1:0];
          we_q    <= req_we;
          size_q  <= req_sz;
          wdata_q <= req_wdata;
          rdata_q <= '0;
          beat    <= '0;
          last_q  <= req_last;
          cnt     <= wait_n;
          st      <= S_ACC;
        end
        S_ACC: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!mem_wait) begin
            if (!we_q)
              for (int j = 0; j < 4; j++)
                if (bmask[j]) rdata_q[8*j +: 8] <= rd_sh[8*j +: 8];
            fin_q <= is_last;
            if (!is_last) beat <= beat + 1'b1;
            if (stop_n != '0) begin
              st  <= S_STOP;
              cnt <= stop_n - 1'b1;
            end else if (is_last) st <= S_IDLE;
            else cnt <= wait_n;
          end
        end
        S_STOP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (fin_q) st <= S_IDLE;
          else begin
            st  <= S_ACC;
            cnt <= wait_n;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign mem_cs_n  = in_acc ? ~(4'b0001 << area_q) : 4'hF;
  assign mem_oe_n  = !(in_acc && !we_q);
  assign mem_we_n  = !(in_acc && we_q);
  assign mem_ub_n  = !(in_acc && dl == 2'd1 && (size_q != 2'd0 || addr_q[0]));
  assign mem_addr  = {addr_q[AREA_W-1:2], off};
  assign mem_wdata = wdata_q >> {lane, 3'b000};

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~mem_cs_n)); // R1
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!mem_oe_n && !mem_we_n)); // R8
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (&mem_cs_n) |-> (mem_oe_n && mem_we_n && mem_ub_n)); // R5
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_acc && cnt == '0 && mem_wait) |=> ($stable(mem_addr) && $stable(mem_cs_n) && !(&mem_cs_n))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) (!busy && req) |=> busy); // R11
endmodule

// File: tb/tb_mem_area_ctrl.sv
module tb_mem_area_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int WW = 4;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_we = 0, swap_we = 0, swap_in = 0, mem_wait = 0;
  logic [1:0] req_size = 0;
  logic [AW+1:0] req_addr = 0;
  logic [31:0] req_wdata = 0, mem_rdata, rdata, mem_wdata;
  logic [7:0] cfg_width;
  logic [4*WW-1:0] cfg_wait, cfg_stop;
  logic busy, done, mem_oe_n, mem_we_n, mem_ub_n;
  logic [3:0] mem_cs_n;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0, rot = 0;
  int wait_tab[4] = '{0, 2, 1, 3};
  int stop_tab[4] = '{0, 1, 2, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_area_ctrl #(.AREA_W(AW), .WAIT_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .swap_we(swap_we), .swap_in(swap_in), .cfg_width(cfg_width), .cfg_wait(cfg_wait),
    .cfg_stop(cfg_stop), .mem_wait(mem_wait), .mem_rdata(mem_rdata), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata));

  function automatic int wl(int p);
    return (p + rot) % 3;
  endfunction

  function automatic logic [7:0] mb(int p, int a);
    return 8'(a * 37 + p * 91 + 5);
  endfunction

  always_comb begin
    for (int p = 0; p < 4; p++) begin
      cfg_width[2*p +: 2] = 2'(wl(p));
      cfg_wait[p*WW +: WW] = WW'(wait_tab[p]);
      cfg_stop[p*WW +: WW] = WW'(stop_tab[p]);
    end
  end

  always_comb begin
    int mp, md, base;
    mp = 0;
    for (int i = 0; i < 4; i++) if (!mem_cs_n[i]) mp = i;
    md = 1 << wl(mp);
    base = int'(mem_addr) & ~(md - 1);
    for (int i = 0; i < 4; i++) mem_rdata[8*i +: 8] = (i < md) ? mb(mp, base + i) : 8'hEE;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic set_swap(input bit v);
    @(negedge clk); swap_we = 1; swap_in = v;
    @(negedge clk); swap_we = 0;
  endtask

  task automatic access(input int sw, input int la, input int sz, input int lo,
                        input int we, input int x, input int mid);
    int p, dl, d, bytes, n, w, s, len, start, span, wb;
    logic [31:0] wd, exp_rd, exp_wd;
    logic [AW-1:0] ea;
    string rcs;
    p = (sw != 0 && (la == 0 || la == 3)) ? 3 - la : la;
    rcs = (p != la) ? "R2" : "R1";
    dl = wl(p); d = 1 << dl; bytes = 1 << sz;
    n = (bytes > d) ? bytes / d : 1;
    w = wait_tab[p]; s = stop_tab[p];
    len = ((w > x) ? w : x) + 1;
    wd = 32'hA1B2C3D4 ^ (32'(mid) << 7);
    @(negedge clk);
    req = 1; req_we = we[0]; req_size = 2'(sz); req_wdata = wd;
    req_addr = {2'(la), 18'(mid), 2'(lo)};
    @(negedge clk);
    req = 0;
    for (int k = 0; k < n; k++) begin
      ea = {18'(mid), 2'(lo + k * d)};
      for (int c = 0; c < len; c++) begin
        chk(mem_cs_n == ~(4'b0001 << p), rcs, 32'(mem_cs_n), 32'(~(4'b0001 << p)));
        chk(mem_addr == ea, "R6", 32'(mem_addr), 32'(ea));
        chk(mem_oe_n == we[0] && mem_we_n == !we[0], "R8", {mem_oe_n, mem_we_n}, {we[0], !we[0]});
        chk(mem_ub_n == !(d == 2 && (sz != 0 || lo[0])), "R9", 32'(mem_ub_n), 32'(!(d == 2 && (sz != 0 || lo[0]))));
        if (we != 0) begin
          exp_wd = wd >> (8 * ((lo + k * d) & ~(d - 1)));
          if (d < 4) exp_wd = exp_wd & ((32'h1 << (8 * d)) - 1);
          chk((mem_wdata & ((d == 4) ? 32'hFFFFFFFF : ((32'h1 << (8 * d)) - 1))) == exp_wd, "R7",
              mem_wdata, exp_wd);
        end
        chk(done == 0, (x > w) ? "R4" : "R3", 32'(done), 0);
        mem_wait = (c < x);
        @(negedge clk);
      end
      mem_wait = 0;
      chk(done == (k == n - 1), "R10", 32'(done), 32'(k == n - 1));
      if (k == n - 1 && we == 0) begin
        start = (d > bytes) ? (lo & ~(d - 1)) : lo;
        span  = (d > bytes) ? d : bytes;
        wb = mid << 2;
        exp_rd = 0;
        for (int j = 0; j < 4; j++)
          if (j >= start && j < start + span) exp_rd[8*j +: 8] = mb(p, wb + j);
        chk(rdata == exp_rd, "R7", rdata, exp_rd);
      end
      for (int t = 0; t < s; t++) begin
        chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n && mem_ub_n && busy, "R5",
            {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, busy}, 32'hFF);
        @(negedge clk);
      end
    end
    chk(busy == 0, "R11", 32'(busy), 0);
  endtask

  initial begin
    int iter, ndone, bad_cs;
    repeat (3) @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n && mem_ub_n, "R1", 32'(mem_cs_n), 32'hF);
    chk(busy == 0 && done == 0, "R11", {busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_cs_n == 4'hF && busy == 0, "R1", 32'(mem_cs_n), 32'hF);

    iter = 0;
    for (int r = 0; r < 3; r++) begin
      rot = r;
      for (int sw = 0; sw < 2; sw++) begin
        set_swap(sw[0]);
        for (int la = 0; la < 4; la++)
          for (int sz = 0; sz < 3; sz++)
            for (int lo = 0; lo < 4; lo += (1 << sz))
              for (int we = 0; we < 2; we++)
                for (int xi = 0; xi < 2; xi++) begin
                  iter++;
                  access(sw, la, sz, lo, we, xi * 3, (iter * 2731) & 18'h3FFFF);
                end
      end
    end

    rot = 0;
    set_swap(1'b0);
    @(negedge clk);
    req = 1; req_we = 0; req_size = 2'd2; req_addr = {2'd3, 18'h00155, 2'd0};
    @(negedge clk);
    req = 1; req_addr = {2'd1, 18'h00AAA, 2'd0};
    swap_we = 1; swap_in = 1;
    @(negedge clk);
    req = 0; swap_we = 0;
    ndone = 0; bad_cs = 0;
    for (int c = 0; c < 60; c++) begin
      if (done) ndone++;
      if (mem_cs_n != 4'hF && mem_cs_n != 4'b0111) bad_cs++;
      @(negedge clk);
    end
    chk(ndone == 1, "R11", 32'(ndone), 1);
    chk(bad_cs == 0, "R2", 32'(bad_cs), 0);
    access(1, 3, 0, 2, 0, 0, 18'h00321);
    access(1, 1, 1, 2, 1, 0, 18'h00123);
    set_swap(1'b0);
    access(0, 0, 2, 0, 1, 2, 18'h3FFFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule